// File: doc/BRIEF.md
# Watchdog Timer with Keyed Service Unlock

This block is a watchdog peripheral with four 16-bit registers reached over a simple single-cycle write port with a combinational read port. Software sets an 8-bit timeout field and turns the watchdog on. From then on a countdown runs on a slow tick input, nominally 32 kHz. Each unit of the timeout field is half a second, or `HALF_TICKS` ticks. The countdown restarts only when the service register receives the key pair 0x5555 and then 0xAAAA. If the countdown runs out, the block raises a sticky system-reset request and records the cause in a status register that only power-on reset clears. The block can be set to drive its active-low watchdog pin instead.

Once set, the enable bit stays set, so the watchdog cannot be stopped. The low-power pause bit can be written once only. A software-reset request needs two writes within one slow-tick period. A separate power-down counter starts at reset and pulses the watchdog pin once unless software turns it off.

Top module: `wdt_top`

## Requirements
- R1: After reset, the control register (offset 0x0) reads 0x0010, the service (0x2) and status (0x4) registers read 0x0000, the misc register (0x8) reads 0x0001, `timeoutRst` and `swRst` are 0, and `wdogOutN` is 1.
- R2: The control register holds the timeout field N in bits 15:8 and the enable bit in bit 2. With N set, the countdown expires on the (N+1)·HALF_TICKS-th tick after the enabling write, and not before.
- R3: Writing bit 2 of the control register as 0 never clears a set enable bit.
- R4: The countdown restarts from the timeout field only when a service write of 0x5555 is followed directly by a service write of 0xAAAA. A lone 0xAAAA, or a pair broken by any other value, has no effect.
- R5: Bit 0 of the control register (pause-in-low-power) takes the value of the first control write after reset, and later writes do not change it. While this bit is 1 and `lowPower` is high, the countdown holds.
- R6: On expiry with bit 3 of the control register at 0, `timeoutRst` goes high and stays high, and status bit 1 reads 1.
- R7: On expiry with bit 3 at 1, `wdogOutN` goes low and stays low, while `timeoutRst` and status bit 1 stay 0.
- R8: Two control writes with bit 4 at 0 while enabled, with no tick between them, raise a sticky `swRst` and set status bit 0. Bit 4 reads back as 1. Writes made before enable, or split by a tick, do not raise `swRst`.
- R9: After `PD_TICKS` ticks from reset, `wdogOutN` pulses low for exactly one clock, once. Writing 0x0000 to the misc register beforehand stops the pulse. Misc then reads 0 and cannot be set again.
- R10: A new timeout written while the countdown runs does not change the current countdown. It applies from the next restart.
- R11: Writes to the status register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low power-on reset |
| tick | input | 1 | One-clock pulse per slow-clock period |
| lowPower | input | 1 | High while the system is in low-power mode |
| wrEn | input | 1 | Register write strobe |
| busAddr | input | 4 | Register byte offset |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for `busAddr` |
| timeoutRst | output | 1 | Sticky system-reset request on timeout |
| swRst | output | 1 | Sticky software-reset request |
| wdogOutN | output | 1 | Active-low watchdog pin |

## Verification
The bound checker checks on every cycle that both reset requests stay high once set, that a held-low watchdog pin stays low, and that expiry happens only on a tick, while the countdown runs and not during a restart. It also checks that a power-down pulse lasts one cycle and comes only while that counter is enabled. The exact expiry tick counts, the key-pair ordering, the write-once and sticky control bits, the two-writes rule for software reset, and the deferred timeout change involve register contents and tick counts. Only the bench's scenarios can show those.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int TW = 8;

  localparam logic [3:0] OFF_CTRL = 4'h0;
  localparam logic [3:0] OFF_SVC  = 4'h2;
  localparam logic [3:0] OFF_STAT = 4'h4;
  localparam logic [3:0] OFF_MISC = 4'h8;

  localparam int BIT_PAUSE = 0;
  localparam int BIT_EN    = 2;
  localparam int BIT_RSEL  = 3;
  localparam int BIT_SRS   = 4;

  localparam logic [15:0] KEY_ARM  = 16'h5555;
  localparam logic [15:0] KEY_FIRE = 16'hAAAA;

  typedef struct packed {
    logic load;
    logic run;
    logic pdRun;
  } wdtStrobes_t;
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int HALF_TICKS = 16384,
  parameter int PD_TICKS   = 524288
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  wdtStrobes_t   stb,
  input  logic [TW-1:0] loadVal,
  output logic          expireStb,
  output logic          pdPulse
);
  localparam int PW  = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam int PDW = (PD_TICKS > 1) ? $clog2(PD_TICKS) : 1;
  localparam logic [PW-1:0]  PRE_LAST = PW'(HALF_TICKS - 1);
  localparam logic [PDW-1:0] PD_LAST  = PDW'(PD_TICKS - 1);

  logic [PW-1:0]  preCnt;
  logic [TW-1:0]  halfCnt;
  logic           doneQ;
  logic           step;
  logic           preEnd;
  logic [PDW-1:0] pdCnt;
  logic           pdDone;
  logic           pdPulseQ;

  assign step      = tick && stb.run && !doneQ && !stb.load;
  assign preEnd    = (preCnt == PRE_LAST);
  assign expireStb = step && preEnd && (halfCnt == '0);
  assign pdPulse   = pdPulseQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      halfCnt <= '0;
      doneQ   <= 1'b0;
    end else if (stb.load && !doneQ) begin
      preCnt  <= '0;
      halfCnt <= loadVal;
    end else if (step) begin
      if (preEnd) begin
        preCnt <= '0;
        if (halfCnt == '0) doneQ <= 1'b1;
        else               halfCnt <= halfCnt - 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdCnt    <= '0;
      pdDone   <= 1'b0;
      pdPulseQ <= 1'b0;
    end else begin
      pdPulseQ <= 1'b0;
      if (tick && stb.pdRun && !pdDone) begin
        if (pdCnt == PD_LAST) begin
          pdPulseQ <= 1'b1;
          pdDone   <= 1'b1;
        end else begin
          pdCnt <= pdCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int SRS_HITS = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  logic          lowPower,
  input  logic          wrEn,
  input  logic [3:0]    busAddr,
  input  logic [15:0]   wrData,
  input  logic          expireStb,
  input  logic          pdPulse,
  output logic [15:0]   rdData,
  output wdtStrobes_t   stb,
  output logic [TW-1:0] loadVal,
  output logic          timeoutRst,
  output logic          swRst,
  output logic          wdogOutN
);
  localparam int SW = $clog2(SRS_HITS + 1);
  localparam logic [SW-1:0] SRS_MAX = SW'(SRS_HITS);

  logic ctrlWr, svcWr, miscWr;
  logic [TW-1:0] timeoutQ;
  logic rselQ, enQ, pauseQ, pauseLockQ;
  logic armedQ, reloadEv, startEv;
  logic [SW-1:0] srsCntQ, srsBase, srsNext;
  logic srsHit;
  logic toutQ, wdogHoldQ, swQ, pdEnQ;

  assign ctrlWr = wrEn && (busAddr == OFF_CTRL);
  assign svcWr  = wrEn && (busAddr == OFF_SVC);
  assign miscWr = wrEn && (busAddr == OFF_MISC);

  assign startEv  = ctrlWr && wrData[BIT_EN] && !enQ;
  assign reloadEv = svcWr && armedQ && (wrData == KEY_FIRE);
  assign srsHit   = ctrlWr && !wrData[BIT_SRS] && enQ;
  assign srsBase  = tick ? '0 : srsCntQ;
  assign srsNext  = srsBase + SW'(srsHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeoutQ   <= '0;
      rselQ      <= 1'b0;
      enQ        <= 1'b0;
      pauseQ     <= 1'b0;
      pauseLockQ <= 1'b0;
    end else if (ctrlWr) begin
      timeoutQ <= wrData[15:8];
      rselQ    <= wrData[BIT_RSEL];
      if (wrData[BIT_EN]) enQ <= 1'b1;
      if (!pauseLockQ) begin
        pauseQ     <= wrData[BIT_PAUSE];
        pauseLockQ <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armedQ <= 1'b0;
    else if (svcWr) armedQ <= (wrData == KEY_ARM);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srsCntQ <= '0;
      swQ     <= 1'b0;
    end else begin
      if (srsNext >= SRS_MAX) begin
        srsCntQ <= SRS_MAX;
        swQ     <= 1'b1;
      end else begin
        srsCntQ <= srsNext;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toutQ     <= 1'b0;
      wdogHoldQ <= 1'b0;
      pdEnQ     <= 1'b1;
    end else begin
      if (expireStb) begin
        if (rselQ) wdogHoldQ <= 1'b1;
        else       toutQ     <= 1'b1;
      end
      if (miscWr && (wrData == 16'h0000)) pdEnQ <= 1'b0;
    end
  end

  assign stb.load  = startEv || (reloadEv && enQ);
  assign stb.run   = enQ && !(pauseQ && lowPower);
  assign stb.pdRun = pdEnQ;
  assign loadVal   = ctrlWr ? wrData[15:8] : timeoutQ;

  assign timeoutRst = toutQ;
  assign swRst      = swQ;
  assign wdogOutN   = !(wdogHoldQ || pdPulse);

  always_comb begin
    rdData = 16'h0000;
    case (busAddr)
      OFF_CTRL: begin
        rdData[15:8]      = timeoutQ;
        rdData[BIT_SRS]   = 1'b1;
        rdData[BIT_RSEL]  = rselQ;
        rdData[BIT_EN]    = enQ;
        rdData[BIT_PAUSE] = pauseQ;
      end
      OFF_STAT: rdData[1:0] = {toutQ, swQ};
      OFF_MISC: rdData[0]   = pdEnQ;
      default:  rdData = 16'h0000;
    endcase
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int HALF_TICKS = 16384,
  parameter int PD_TICKS   = 524288,
  parameter int SRS_HITS   = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        lowPower,
  input  logic        wrEn,
  input  logic [3:0]  busAddr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output logic        timeoutRst,
  output logic        swRst,
  output logic        wdogOutN
);
  wdtStrobes_t   stb;
  logic [TW-1:0] loadVal;
  logic          expireStb;
  logic          pdPulse;

  wdt_ctrl #(.SRS_HITS(SRS_HITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .lowPower(lowPower),
    .wrEn(wrEn), .busAddr(busAddr), .wrData(wrData),
    .expireStb(expireStb), .pdPulse(pdPulse),
    .rdData(rdData), .stb(stb), .loadVal(loadVal),
    .timeoutRst(timeoutRst), .swRst(swRst), .wdogOutN(wdogOutN)
  );

  wdt_datapath #(.HALF_TICKS(HALF_TICKS), .PD_TICKS(PD_TICKS)) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .stb(stb), .loadVal(loadVal),
    .expireStb(expireStb), .pdPulse(pdPulse)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        tick,
  input wdtStrobes_t stb,
  input logic        expireStb,
  input logic        pdPulse,
  input logic        timeoutRst,
  input logic        swRst,
  input logic        wdogOutN
);
  p_expire_on_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    expireStb |-> tick);

  p_load_blocks_expire_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |-> !expireStb);

  p_expire_needs_run_r5: assert property (@(posedge clk) disable iff (!rstN)
    !stb.run |-> !expireStb);

  p_tout_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    timeoutRst |=> timeoutRst);

  p_wdog_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!wdogOutN && !pdPulse) |=> !wdogOutN);

  p_sw_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    swRst |=> swRst);

  p_pd_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    pdPulse |=> !pdPulse);

  p_pd_needs_enable_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pdPulse) |-> $past(stb.pdRun));
endmodule

bind wdt_top wdt_checker u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .stb(stb),
  .expireStb(expireStb), .pdPulse(pdPulse),
  .timeoutRst(timeoutRst), .swRst(swRst), .wdogOutN(wdogOutN)
);

// File: tb/tb_wdt_top.sv
`timescale 1ns/1ps
module tb_wdt_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        lowPower = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  busAddr = 4'h0;
  logic [15:0] wrData = 16'h0;
  logic [15:0] rdData;
  logic        timeoutRst, swRst, wdogOutN;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  wdt_top #(.HALF_TICKS(4), .PD_TICKS(20), .SRS_HITS(2)) dut (
    .clk(clk), .rstN(rstN), .tick(tick), .lowPower(lowPower),
    .wrEn(wrEn), .busAddr(busAddr), .wrData(wrData), .rdData(rdData),
    .timeoutRst(timeoutRst), .swRst(swRst), .wdogOutN(wdogOutN)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset(input bit killPd);
    @(negedge clk);
    rstN = 1'b0; tick = 1'b0; lowPower = 1'b0; wrEn = 1'b0;
    busAddr = 4'h0; wrData = 16'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    if (killPd) writeReg(4'h8, 16'h0000);
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; busAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [3:0] a, output logic [15:0] d);
    busAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [15:0] v;
    doReset(1'b0);
    readReg(4'h0, v); check("R1 ctrl", v, 16'h0010);
    readReg(4'h2, v); check("R1 service", v, 16'h0000);
    readReg(4'h4, v); check("R1 status", v, 16'h0000);
    readReg(4'h8, v); check("R1 misc", v, 16'h0001);
    check("R1 outputs", {13'b0, timeoutRst, swRst, wdogOutN}, 16'h0001);
  endtask

  task automatic t_expiry();
    logic [15:0] v;
    doReset(1'b1);
    writeReg(4'h0, 16'h0114);
    ticks(7); check("R2 before N=1", {15'b0, timeoutRst}, 16'h0);
    ticks(1); check("R2 at N=1", {15'b0, timeoutRst}, 16'h1);
    readReg(4'h4, v); check("R6 status tout", v, 16'h0002);
    ticks(3); check("R6 sticky", {15'b0, timeoutRst}, 16'h1);
    writeReg(4'h4, 16'h0000);
    readReg(4'h4, v); check("R11 status write ignored", v, 16'h0002);
    doReset(1'b1);
    writeReg(4'h4, 16'hFFFF);
    readReg(4'h4, v); check("R11 status stays 0", v, 16'h0000);
    writeReg(4'h0, 16'h0014);
    ticks(3); check("R2 before N=0", {15'b0, timeoutRst}, 16'h0);
    ticks(1); check("R2 at N=0", {15'b0, timeoutRst}, 16'h1);
  endtask

  task automatic t_service();
    doReset(1'b1);
    writeReg(4'h0, 16'h0114);
    ticks(6);
    writeReg(4'h2, 16'h5555);
    writeReg(4'h2, 16'hAAAA);
    ticks(7); check("R4 reload held off", {15'b0, timeoutRst}, 16'h0);
    writeReg(4'h2, 16'hAAAA);
    ticks(1); check("R4 lone key ignored", {15'b0, timeoutRst}, 16'h1);
    doReset(1'b1);
    writeReg(4'h0, 16'h0114);
    ticks(6);
    writeReg(4'h2, 16'h5555);
    writeReg(4'h2, 16'h1234);
    writeReg(4'h2, 16'hAAAA);
    ticks(1); check("R4 broken pair no reload", {15'b0, timeoutRst}, 16'h0);
    ticks(1); check("R4 broken pair expires", {15'b0, timeoutRst}, 16'h1);
  endtask

  task automatic t_sticky_enable();
    logic [15:0] v;
    doReset(1'b1);
    writeReg(4'h0, 16'h0114);
    writeReg(4'h0, 16'h0110);
    readReg(4'h0, v); check("R3 enable sticky", v, 16'h0114);
    ticks(8); check("R3 still counts", {15'b0, timeoutRst}, 16'h1);
  endtask

  task automatic t_pause();
    logic [15:0] v;
    doReset(1'b1);
    writeReg(4'h0, 16'h0111);
    writeReg(4'h0, 16'h0114);
    readReg(4'h0, v); check("R5 pause locked at 1", v, 16'h0115);
    lowPower = 1'b1;
    ticks(20); check("R5 paused", {15'b0, timeoutRst}, 16'h0);
    lowPower = 1'b0;
    ticks(7); check("R5 resumed before", {15'b0, timeoutRst}, 16'h0);
    ticks(1); check("R5 resumed expiry", {15'b0, timeoutRst}, 16'h1);
    doReset(1'b1);
    writeReg(4'h0, 16'h0010);
    writeReg(4'h0, 16'h0115);
    readReg(4'h0, v); check("R5 pause locked at 0", v, 16'h0114);
    lowPower = 1'b1;
    ticks(8); check("R5 no pause when clear", {15'b0, timeoutRst}, 16'h1);
    lowPower = 1'b0;
  endtask

  task automatic t_pin_select();
    logic [15:0] v;
    doReset(1'b1);
    writeReg(4'h0, 16'h011C);
    ticks(7); check("R7 pin before", {15'b0, wdogOutN}, 16'h1);
    ticks(1); check("R7 pin low", {14'b0, timeoutRst, wdogOutN}, 16'h0);
    readReg(4'h4, v); check("R7 status clear", v, 16'h0000);
    ticks(2); check("R7 pin held", {15'b0, wdogOutN}, 16'h0);
  endtask

  task automatic t_swreset();
    logic [15:0] v;
    doReset(1'b1);
    writeReg(4'h0, 16'h0100);
    writeReg(4'h0, 16'h0100);
    check("R8 not enabled", {15'b0, swRst}, 16'h0);
    writeReg(4'h0, 16'h0114);
    readReg(4'h0, v); check("R8 srs reads 1", v & 16'h0010, 16'h0010);
    writeReg(4'h0, 16'h0104);
    check("R8 one write", {15'b0, swRst}, 16'h0);
    writeReg(4'h0, 16'h0104);
    check("R8 two writes", {15'b0, swRst}, 16'h1);
    readReg(4'h4, v); check("R8 status", v, 16'h0001);
    doReset(1'b1);
    writeReg(4'h0, 16'h0F14);
    writeReg(4'h0, 16'h0F04);
    ticks(1);
    writeReg(4'h0, 16'h0F04);
    check("R8 split by tick", {15'b0, swRst}, 16'h0);
  endtask

  task automatic t_powerdown();
    logic [15:0] v;
    doReset(1'b0);
    ticks(19); check("R9 no early pulse", {15'b0, wdogOutN}, 16'h1);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    check("R9 pulse low", {15'b0, wdogOutN}, 16'h0);
    @(negedge clk);
    check("R9 one cycle", {15'b0, wdogOutN}, 16'h1);
    ticks(25); check("R9 once only", {15'b0, wdogOutN}, 16'h1);
    doReset(1'b1);
    readReg(4'h8, v); check("R9 misc cleared", v, 16'h0000);
    writeReg(4'h8, 16'h0001);
    readReg(4'h8, v); check("R9 misc stays off", v, 16'h0000);
    for (int i = 0; i < 30; i++) begin
      ticks(1);
      if (!wdogOutN) check("R9 disabled no pulse", 16'h0, 16'h1);
    end
    check("R9 disabled end", {15'b0, wdogOutN}, 16'h1);
  endtask

  task automatic t_change();
    doReset(1'b1);
    writeReg(4'h0, 16'h0114);
    ticks(2);
    writeReg(4'h0, 16'h0314);
    ticks(5); check("R10 old timeout kept", {15'b0, timeoutRst}, 16'h0);
    writeReg(4'h2, 16'h5555);
    writeReg(4'h2, 16'hAAAA);
    ticks(15); check("R10 new before", {15'b0, timeoutRst}, 16'h0);
    ticks(1); check("R10 new at expiry", {15'b0, timeoutRst}, 16'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_expiry();
    t_service();
    t_sticky_enable();
    t_pause();
    t_pin_select();
    t_swreset();
    t_powerdown();
    t_change();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule